// File: doc/BRIEF.md
# Bit-Banged Serial EEPROM Responder

This block answers for a 64-word by 16-bit serial EEPROM whose pins are not real wires. Software toggles the chip select, the serial clock and the serial data input by writing bits into a control register. The block finds clock and select edges by comparing each control write with the value stored by the previous write. After a select rising edge it shifts in a 3-bit read opcode and a 6-bit word address. Each later falling edge then moves the data-out bit, seen in the control register readback, one position along the stored words.

A second, register-style port gives direct word reads. Software writes an address together with a start bit, and the readback returns the addressed word with a done flag. The contents are fixed when the block is built: a 6-byte station address in the first three words, a fixed filler pattern, and a final checksum word. Only reads are modelled.

Top module: `nvm_serial_resp`

## Requirements
- R1: After reset, `ctl_rdata` and `rd_rdata` are both zero.
- R2: A control write stores bit 0 (serial clock), bit 1 (chip select), bit 2 (data in), bits 5:4 (write enable) and bit 6 (request), and `ctl_rdata` returns them in the same positions. Bit 3 of `ctl_rdata` is the serial data-out. Bit 7 reads as zero. Written values of bits 3 and 7 are ignored.
- R3: A control write with chip select (bit 1) low changes nothing but the stored control value. The data-out bit and the serial progress stay as they were.
- R4: A control write that raises chip select clears the input shift register, the input bit count, the output position and the reading flag. Data-out reads 0 until a new read command has been completed.
- R5: With chip select held high, a rising clock edge shifts the data-in bit into the LSB of the input shift register. The 9th bit after a select rise completes a command. If the first three bits, MSB first, are 110, the command is a read and the next six bits, MSB first, give the start word. The reading flag is then set.
- R6: With chip select held high, each falling clock edge advances the output position by one. After the k-th falling edge (k starting at 1) that follows a read command, data-out equals bit 15-((k-1) mod 16) of word (start + (k-1) div 16) mod 64. Reading therefore runs on into the next word and wraps from word 63 to word 0.
- R7: When the first three command bits are not 110, the reading flag stays clear and data-out stays 0 on every later falling edge.
- R8: A write to the read register with start (bit 0) clear makes `rd_rdata` return the written 32-bit value unchanged.
- R9: When start is set and the address field (bits 15:8) is at most 63, `rd_rdata` is laid out as follows. Bits 31:16 hold the addressed word. Bits 15:0 hold the written low half with bit 0 cleared and done (bit 4) set.
- R10: When start is set and the address field is above 63, bits 31:16 of `rd_rdata` are zero. Bits 15:0 hold the written low half with bit 0 cleared and done set.
- R11: Words 0 to 2 hold the station address `MAC_ADDR`, two bytes per word. The byte sent first (bits 47:40) is the low byte of word 0. Word i for 3 ≤ i ≤ 62 is {i[7:0], ~i[7:0]}. Word 63 makes the 16-bit sum of all 64 words equal 0xBABA.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write value (clock, select, data-in, write enable, request) |
| ctl_rdata | output | 8 | Stored control value with serial data-out in bit 3 |
| rd_wr | input | 1 | Read register write strobe |
| rd_wdata | input | 32 | Read register write value (start, address, data fields) |
| rd_rdata | output | 32 | Read register readback with done and word data |

## Verification
The hardest situations to reach are the ones where chip select changes while a read is in progress. A select rise that lands mid-stream has to wipe the reading flag and the position. Clock toggles made while select is low must leave both alone. The stimulus builds a full read command, clocks out a few bits, and then toggles the clock several times with select low, checking that data-out holds the same bit. It then raises select with the clock level unchanged and checks that data-out falls to zero. A further case shifts some stray bits first, then runs a complete command and checks that the correct word follows.

// File: rtl/nvm_serial_resp.sv
module nvm_serial_resp #(
  parameter int          WORDS    = 64,
  parameter logic [47:0] MAC_ADDR = 48'h021A4FC3907E,
  parameter logic [15:0] CK_SUM   = 16'hBABA
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_wr,
  input  logic [7:0]  ctl_wdata,
  output logic [7:0]  ctl_rdata,
  input  logic        rd_wr,
  input  logic [31:0] rd_wdata,
  output logic [31:0] rd_rdata
);
  localparam int AW   = $clog2(WORDS);
  localparam int IN_W = 3 + AW;
  localparam int PW   = AW + 4;
  localparam logic [7:0] LAST = 8'(WORDS - 1);
  localparam logic [2:0] OP_READ = 3'b110;

  function automatic logic [WORDS*16-1:0] build_rom();
    logic [WORDS*16-1:0] r;
    logic [15:0] sum, w;
    r = '0;
    sum = '0;
    for (int i = 0; i < WORDS - 1; i++) begin
      if (i < 3) w = {8'(MAC_ADDR >> (32 - 16*i)), 8'(MAC_ADDR >> (40 - 16*i))};
      else       w = {8'(i), ~8'(i)};
      r[16*i +: 16] = w;
      sum = sum + w;
    end
    r[16*(WORDS-1) +: 16] = CK_SUM - sum;
    return r;
  endfunction

  localparam logic [WORDS*16-1:0] ROM = build_rom();

  logic [5:0]      ctl_q;
  logic [IN_W-1:0] in_sr, n_sr;
  logic [3:0]      in_cnt, n_cnt;
  logic            reading, n_rd;
  logic [PW-1:0]   pos, n_pos;
  logic [31:0]     rd_q;

  wire w_sk = ctl_wdata[0];
  wire w_cs = ctl_wdata[1];
  wire w_di = ctl_wdata[2];
  wire p_sk = ctl_q[0];
  wire p_cs = ctl_q[1];

  always_comb begin
    n_sr  = in_sr;
    n_cnt = in_cnt;
    n_rd  = reading;
    n_pos = pos;
    if (ctl_wr && w_cs) begin
      if (!p_cs) begin
        n_sr  = '0;
        n_cnt = '0;
        n_rd  = 1'b0;
        n_pos = '0;
      end
      if (w_sk != p_sk) begin
        if (!w_sk) begin
          n_pos = n_pos + 1'b1;
        end else begin
          n_sr = {n_sr[IN_W-2:0], w_di};
          if (n_cnt != 4'hF) n_cnt = n_cnt + 1'b1;
          if (n_cnt == 4'(IN_W) && !n_rd && n_sr[IN_W-1 -: 3] == OP_READ) begin
            n_rd  = 1'b1;
            n_pos = {n_sr[AW-1:0], 4'h0} - 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      in_sr   <= '0;
      in_cnt  <= '0;
      reading <= 1'b0;
      pos     <= '0;
      rd_q    <= '0;
    end else begin
      if (ctl_wr) ctl_q <= {ctl_wdata[6:4], ctl_wdata[2:0]};
      in_sr   <= n_sr;
      in_cnt  <= n_cnt;
      reading <= n_rd;
      pos     <= n_pos;
      if (rd_wr) rd_q <= rd_wdata;
    end
  end

  wire dout = reading & ROM[{pos[PW-1:4], ~pos[3:0]}];
  assign ctl_rdata = {1'b0, ctl_q[5:3], dout, ctl_q[2:0]};

  wire [7:0]  rd_addr = rd_q[15:8];
  wire [15:0] rd_low  = (rd_q[15:0] & 16'hFFFE) | 16'h0010;
  wire [15:0] rd_word = ROM[{rd_addr[AW-1:0], 4'h0} +: 16];

  assign rd_rdata = !rd_q[0]        ? rd_q :
                    (rd_addr > LAST) ? {16'h0000, rd_low} :
                                       {rd_word, rd_low};

  logic unused_bits;
  assign unused_bits = ^{ctl_wdata[7], ctl_wdata[3]};
endmodule

// File: rtl/nvm_serial_resp_chk.sv
module nvm_serial_resp_chk #(
  parameter int WORDS = 64,
  parameter int IN_W  = 9,
  parameter int PW    = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ctl_wr,
  input logic [7:0]      ctl_wdata,
  input logic [7:0]      ctl_rdata,
  input logic            rd_wr,
  input logic [31:0]     rd_wdata,
  input logic [31:0]     rd_rdata,
  input logic [5:0]      ctl_q,
  input logic [IN_W-1:0] in_sr,
  input logic [3:0]      in_cnt,
  input logic            reading,
  input logic [PW-1:0]   pos
);
  a_r3_cs_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && !ctl_wdata[1] |=> $stable(in_sr) && $stable(in_cnt) && $stable(reading) && $stable(pos));

  a_r4_cs_rise_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && ctl_wdata[1] && !ctl_q[1] |=> !reading && !ctl_rdata[3]);

  a_r5_rise_shifts: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && ctl_wdata[1] && ctl_q[1] && !ctl_q[0] && ctl_wdata[0]
    |=> in_sr == {$past(in_sr[IN_W-2:0]), $past(ctl_wdata[2])});

  a_r6_fall_advances: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && ctl_wdata[1] && ctl_q[1] && ctl_q[0] && !ctl_wdata[0]
    |=> pos == $past(pos) + 1'b1 && $stable(in_sr));

  a_r8_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    rd_wr && !rd_wdata[0] |=> rd_rdata == $past(rd_wdata));

  a_r10_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
    rd_wr && rd_wdata[0] && rd_wdata[15:8] > 8'(WORDS - 1)
    |=> rd_rdata[31:16] == 16'h0000 && rd_rdata[4] && !rd_rdata[0]);
endmodule

bind nvm_serial_resp nvm_serial_resp_chk #(.WORDS(WORDS), .IN_W(IN_W), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
  .rd_wr(rd_wr), .rd_wdata(rd_wdata), .rd_rdata(rd_rdata), .ctl_q(ctl_q),
  .in_sr(in_sr), .in_cnt(in_cnt), .reading(reading), .pos(pos)
);

// File: tb/test_nvm_serial_resp.sv
`timescale 1ns/1ps
module test_nvm_serial_resp;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_wr = 1'b0;
  logic [7:0]  ctl_wdata = '0;
  logic [7:0]  ctl_rdata;
  logic        rd_wr = 1'b0;
  logic [31:0] rd_wdata = '0;
  logic [31:0] rd_rdata;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  int          q_sel[$];
  logic [31:0] q_exp[$];
  string       q_req[$];

  always #2 clk = ~clk;

  nvm_serial_resp #(.MAC_ADDR(48'h021A4FC3907E)) i_nvm_serial_resp (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .rd_wr(rd_wr), .rd_wdata(rd_wdata), .rd_rdata(rd_rdata)
  );

  function automatic logic [15:0] base_word(int i);
    case (i)
      0: return 16'h1A02;
      1: return 16'hC34F;
      2: return 16'h7E90;
      default: return {8'(i), ~8'(i)};
    endcase
  endfunction

  function automatic logic [15:0] ref_word(int i);
    logic [15:0] s;
    if (i != 63) return base_word(i);
    s = '0;
    for (int j = 0; j < 63; j++) s = s + base_word(j);
    return 16'hBABA - s;
  endfunction

  function automatic logic [7:0] cb(bit cs, bit sk, bit di);
    return {5'b00000, di, cs, sk};
  endfunction

  task automatic expect_v(int sel, logic [31:0] e, string r);
    q_sel.push_back(sel);
    q_exp.push_back(e);
    q_req.push_back(r);
  endtask

  always @(negedge clk) begin
    while (q_sel.size() > 0) begin
      int s;
      logic [31:0] e, a;
      string r;
      s = q_sel.pop_front();
      e = q_exp.pop_front();
      r = q_req.pop_front();
      a = (s == 0) ? {24'h0, ctl_rdata} : rd_rdata;
      n_vec++;
      if (a !== e) begin
        n_bad++;
        $display("FAIL %s: got %h expected %h", r, a, e);
      end
    end
  end

  task automatic ctl(logic [7:0] d);
    @(negedge clk);
    ctl_wr = 1'b1;
    ctl_wdata = d;
    @(posedge clk);
    #1 ctl_wr = 1'b0;
  endtask

  task automatic rdreg(logic [31:0] d);
    @(negedge clk);
    rd_wr = 1'b1;
    rd_wdata = d;
    @(posedge clk);
    #1 rd_wr = 1'b0;
  endtask

  task automatic start_cmd(logic [2:0] op, logic [5:0] a);
    logic [8:0] bits;
    bits = {op, a};
    ctl(cb(0, 0, 0));
    ctl(cb(1, 0, 0));
    for (int b = 8; b >= 0; b--) begin
      ctl(cb(1, 0, bits[b]));
      ctl(cb(1, 1, bits[b]));
    end
  endtask

  task automatic read_bits(int a, int n, string r);
    for (int k = 0; k < n; k++) begin
      logic [15:0] w;
      w = ref_word((a + k / 16) % 64);
      ctl(cb(1, 0, 0));
      expect_v(0, {24'h0, 4'h0, w[15 - (k % 16)], 3'b010}, r);
      if (k != n - 1) ctl(cb(1, 1, 0));
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    expect_v(0, 32'h0, "R1 ctl_rdata after reset");
    expect_v(1, 32'h0, "R1 rd_rdata after reset");

    ctl(8'hFC);
    expect_v(0, 32'h74, "R2 stored fields, bits 3 and 7 ignored");

    start_cmd(3'b110, 6'd0);
    read_bits(0, 16, "R5 R6 R11 word 0 station address");
    start_cmd(3'b110, 6'd2);
    read_bits(2, 16, "R6 R11 word 2 station address");
    start_cmd(3'b110, 6'd5);
    read_bits(5, 16, "R6 R11 filler word 5");
    start_cmd(3'b110, 6'd63);
    read_bits(63, 32, "R6 R11 checksum word then wrap to word 0");

    start_cmd(3'b101, 6'd5);
    for (int k = 0; k < 8; k++) begin
      ctl(cb(1, 0, 0));
      expect_v(0, 32'h02, "R7 non-read opcode gives no data");
      ctl(cb(1, 1, 0));
    end

    start_cmd(3'b110, 6'd1);
    read_bits(1, 4, "R6 word 1 first bits");
    ctl(cb(0, 1, 1));
    expect_v(0, {28'h0, ref_word(1)[12], 3'b101}, "R3 select low, clock high");
    ctl(cb(0, 0, 0));
    expect_v(0, {28'h0, ref_word(1)[12], 3'b000}, "R3 select low, clock low");
    ctl(cb(0, 1, 0));
    expect_v(0, {28'h0, ref_word(1)[12], 3'b001}, "R3 select low, clock high again");
    ctl(cb(1, 1, 0));
    expect_v(0, 32'h03, "R4 select rise drops data-out");
    ctl(cb(1, 0, 0));
    expect_v(0, 32'h02, "R4 falling edge after select rise stays 0");

    ctl(cb(1, 1, 1));
    ctl(cb(1, 0, 1));
    ctl(cb(1, 1, 0));
    start_cmd(3'b110, 6'd10);
    read_bits(10, 16, "R4 R5 fresh command after stray bits");

    rdreg(32'hDEADBE12);
    expect_v(1, 32'hDEADBE12, "R8 start clear passthrough");
    rdreg(32'h12342A01);
    expect_v(1, {ref_word(42), 16'h2A10}, "R9 word 42");
    rdreg(32'hFFFF40E1);
    expect_v(1, 32'h000040F0, "R10 address 64");
    rdreg(32'h0000FF01);
    expect_v(1, 32'h0000FF10, "R10 address 255");
    for (int a = 0; a < 64; a++) begin
      rdreg({16'hA5A5, 8'(a), 8'h01});
      expect_v(1, {ref_word(a), 8'(a), 8'h10}, "R9 R11 register read");
    end

    repeat (3) @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule